// File: doc/BRIEF.md
# In-Order Pipeline Exception Commit Unit

This block handles exceptions and interrupts for a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). It keeps a sideband pipeline next to the datapath. For each slot it holds a valid bit, the instruction's PC and one pending-exception record. A fault found in fetch, decode or execute is attached to its instruction and travels with it. The fault has no effect until the instruction reaches the memory stage. That stage is the single commit point, and it is the only place where a trap can be taken. The exceptions are therefore precise: all older instructions have finished, and no younger one has changed any state.

When a trap is taken, the unit raises a redirect for one cycle carrying a fixed handler PC. In the same cycle it asserts kill strobes for fetch, decode, execute and the writeback of the faulting instruction. On the following clock edge it records a cause code and the faulting PC. An external interrupt is sampled at the commit point and takes precedence over every synchronous fault. It needs a real instruction in the memory stage so that it has a resume PC. The pipeline advances every cycle, so there is no valid/ready handshake. All pins are plain control and status signals, and back-pressure does not apply.

Top module: `exc_commit_unit`

## Requirements
- R1: A fault flagged in fetch, decode or execute never redirects or writes the cause or EPC registers while its instruction is still in that stage. It is taken in the cycle the instruction occupies the memory stage, which is three cycles after fetch. A data address fault flagged in the memory stage is taken in that same cycle.
- R2: When one instruction carries several faults, the earliest stage wins: fetch PC fault beats illegal opcode, illegal opcode beats overflow, and overflow beats data address fault.
- R3: An interrupt asserted while a valid instruction is in the memory stage is taken with cause 0, whatever synchronous faults that instruction carries.
- R4: An interrupt asserted while the memory stage holds a bubble is not taken in that cycle.
- R5: On a take, the cause register is loaded on the next edge with the code (interrupt 0, fetch PC fault 1, illegal opcode 2, overflow 3, data address fault 4). The EPC register is loaded with the PC of the instruction in the memory stage. Both registers hold their values on every other cycle.
- R6: In a take cycle the faulting instruction does not commit. The three younger instructions (those in execute, decode and fetch) are discarded together with any fault flags they carry. None of them commits or traps.
- R7: The redirect lasts exactly one cycle, carries the handler PC parameter, and is accompanied by all four kill strobes.
- R8: A bubble never raises an exception, whatever fault inputs are asserted while it passes through a stage.
- R9: A valid instruction without faults commits for exactly one cycle, in fetch order, with its own PC on the commit outputs.
- R10: After reset the cause and EPC registers read zero, and neither redirect nor commit is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| f_valid_i | input | 1 | Fetch stage holds an instruction |
| f_pc_i | input | PC_W | PC of the fetched instruction |
| f_pc_fault_i | input | 1 | Fetch PC address fault |
| d_illegal_i | input | 1 | Illegal opcode for the instruction in decode |
| e_overflow_i | input | 1 | Arithmetic overflow for the instruction in execute |
| m_data_fault_i | input | 1 | Data address fault for the instruction in memory |
| irq_i | input | 1 | External interrupt request (level) |
| commit_valid_o | output | 1 | Memory-stage instruction may write back |
| commit_pc_o | output | PC_W | PC of the memory-stage instruction |
| redirect_o | output | 1 | One-cycle trap redirect to fetch |
| redirect_pc_o | output | PC_W | Handler PC |
| kill_f_o | output | 1 | Kill fetch stage |
| kill_d_o | output | 1 | Kill decode stage |
| kill_e_o | output | 1 | Kill execute stage |
| kill_wb_o | output | 1 | Suppress writeback of the memory-stage instruction |
| cause_o | output | 3 | Cause register |
| epc_o | output | PC_W | Exception PC register |

## Verification
The first stimulus is a run of clean instructions, which sets the normal one-per-cycle commit order apart from any trap. Next comes each single fault on its own, which shows that each stage's flag is deferred to the commit point and yields its own code. Pairs of faults on one instruction then separate the age priority from an arbitrary order. Fault flags placed on the three instructions behind a trap, together with faults and interrupts placed on bubbles, show whether killed slots and empty slots are really ignored or still leak a trap.

// File: rtl/exc_pkg.sv
package exc_pkg;

  typedef enum logic [2:0] {
    CAUSE_IRQ     = 3'd0,
    CAUSE_PCADDR  = 3'd1,
    CAUSE_ILLEGAL = 3'd2,
    CAUSE_OVFL    = 3'd3,
    CAUSE_DADDR   = 3'd4
  } cause_e;

  // code attached by the flag-collecting slot with this index (fetch first)
  function automatic cause_e slot_code(input int idx);
    case (idx)
      0:       return CAUSE_PCADDR;
      1:       return CAUSE_ILLEGAL;
      default: return CAUSE_OVFL;
    endcase
  endfunction

endpackage

// File: rtl/exc_stage_slot.sv
module exc_stage_slot
  import exc_pkg::*;
#(
  parameter int     PC_W       = 32,
  parameter cause_e RAISE_CODE = CAUSE_PCADDR
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            kill_i,
  input  logic            in_valid_i,
  input  logic [PC_W-1:0] in_pc_i,
  input  logic            in_pend_i,
  input  cause_e          in_code_i,
  input  logic            raise_i,
  output logic            out_valid_o,
  output logic [PC_W-1:0] out_pc_o,
  output logic            out_pend_o,
  output cause_e          out_code_o
);

  logic   nxt_pend;
  cause_e nxt_code;

  // an older record is never overwritten; bubbles never collect a flag
  always_comb begin
    nxt_pend = in_pend_i;
    nxt_code = in_code_i;
    if (in_valid_i && !in_pend_i && raise_i) begin
      nxt_pend = 1'b1;
      nxt_code = RAISE_CODE;
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni || kill_i) begin
      out_valid_o <= 1'b0;
      out_pend_o  <= 1'b0;
      out_code_o  <= CAUSE_IRQ;
      out_pc_o    <= '0;
    end else begin
      out_valid_o <= in_valid_i;
      out_pend_o  <= in_valid_i & nxt_pend;
      out_code_o  <= nxt_code;
      out_pc_o    <= in_pc_i;
    end
  end

endmodule

// File: rtl/exc_commit_arb.sv
module exc_commit_arb
  import exc_pkg::*;
(
  input  logic   m_valid_i,
  input  logic   m_pend_i,
  input  cause_e m_code_i,
  input  logic   data_fault_i,
  input  logic   irq_i,
  output logic   take_o,
  output logic   commit_o,
  output cause_e cause_o
);

  always_comb begin
    take_o   = m_valid_i & (irq_i | m_pend_i | data_fault_i);
    commit_o = m_valid_i & ~take_o;
    if (irq_i)         cause_o = CAUSE_IRQ;
    else if (m_pend_i) cause_o = m_code_i;
    else               cause_o = CAUSE_DADDR;
  end

endmodule

// File: rtl/exc_cause_regs.sv
module exc_cause_regs
  import exc_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            take_i,
  input  cause_e          cause_i,
  input  logic [PC_W-1:0] pc_i,
  output cause_e          cause_q_o,
  output logic [PC_W-1:0] epc_q_o
);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cause_q_o <= CAUSE_IRQ;
      epc_q_o   <= '0;
    end else if (take_i) begin
      cause_q_o <= cause_i;
      epc_q_o   <= pc_i;
    end
  end

endmodule

// File: rtl/exc_commit_unit.sv
module exc_commit_unit
  import exc_pkg::*;
#(
  parameter int              PC_W       = 32,
  parameter logic [PC_W-1:0] HANDLER_PC = 32'h0000_1000
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            f_valid_i,
  input  logic [PC_W-1:0] f_pc_i,
  input  logic            f_pc_fault_i,
  input  logic            d_illegal_i,
  input  logic            e_overflow_i,
  input  logic            m_data_fault_i,
  input  logic            irq_i,
  output logic            commit_valid_o,
  output logic [PC_W-1:0] commit_pc_o,
  output logic            redirect_o,
  output logic [PC_W-1:0] redirect_pc_o,
  output logic            kill_f_o,
  output logic            kill_d_o,
  output logic            kill_e_o,
  output logic            kill_wb_o,
  output logic [2:0]      cause_o,
  output logic [PC_W-1:0] epc_o
);

  localparam int NSLOT = 3;  // fetch->decode, decode->execute, execute->memory

  logic [NSLOT:0]           s_valid;
  logic [NSLOT:0][PC_W-1:0] s_pc;
  logic [NSLOT:0]           s_pend;
  cause_e                   s_code [NSLOT+1];
  logic [NSLOT-1:0]         raise;
  logic                     take;
  logic                     commit;
  cause_e                   take_cause;
  cause_e                   cause_q;

  assign s_valid[0] = f_valid_i;
  assign s_pc[0]    = f_pc_i;
  assign s_pend[0]  = 1'b0;
  assign s_code[0]  = CAUSE_IRQ;
  assign raise      = {e_overflow_i, d_illegal_i, f_pc_fault_i};

  generate
    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
      exc_stage_slot #(
        .PC_W      (PC_W),
        .RAISE_CODE(slot_code(i))
      ) i_slot (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .kill_i     (take),
        .in_valid_i (s_valid[i]),
        .in_pc_i    (s_pc[i]),
        .in_pend_i  (s_pend[i]),
        .in_code_i  (s_code[i]),
        .raise_i    (raise[i]),
        .out_valid_o(s_valid[i+1]),
        .out_pc_o   (s_pc[i+1]),
        .out_pend_o (s_pend[i+1]),
        .out_code_o (s_code[i+1])
      );
    end
  endgenerate

  exc_commit_arb i_arb (
    .m_valid_i   (s_valid[NSLOT]),
    .m_pend_i    (s_pend[NSLOT]),
    .m_code_i    (s_code[NSLOT]),
    .data_fault_i(m_data_fault_i),
    .irq_i       (irq_i),
    .take_o      (take),
    .commit_o    (commit),
    .cause_o     (take_cause)
  );

  exc_cause_regs #(.PC_W(PC_W)) i_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .take_i   (take),
    .cause_i  (take_cause),
    .pc_i     (s_pc[NSLOT]),
    .cause_q_o(cause_q),
    .epc_q_o  (epc_o)
  );

  assign commit_valid_o = commit;
  assign commit_pc_o    = s_pc[NSLOT];
  assign redirect_o     = take;
  assign redirect_pc_o  = HANDLER_PC;
  assign kill_f_o       = take;
  assign kill_d_o       = take;
  assign kill_e_o       = take;
  assign kill_wb_o      = take;
  assign cause_o        = cause_q;

endmodule

// File: rtl/exc_commit_chk.sv
module exc_commit_chk #(
  parameter int              PC_W       = 32,
  parameter logic [PC_W-1:0] HANDLER_PC = 32'h0000_1000
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            irq_i,
  input logic            commit_valid_o,
  input logic [PC_W-1:0] commit_pc_o,
  input logic            redirect_o,
  input logic [PC_W-1:0] redirect_pc_o,
  input logic            kill_wb_o,
  input logic [2:0]      cause_o,
  input logic [PC_W-1:0] epc_o
);

  AST_REDIRECT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |=> !redirect_o); // R7
  AST_HANDLER_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |-> redirect_pc_o == HANDLER_PC); // R7
  AST_NO_WB_ON_TRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |-> (kill_wb_o && !commit_valid_o)); // R6
  AST_SHADOW_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |=> !commit_valid_o ##1 (!commit_valid_o && !redirect_o)
                   ##1 (!commit_valid_o && !redirect_o)); // R6
  AST_EPC_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |=> epc_o == $past(commit_pc_o)); // R5
  AST_REGS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !redirect_o |=> ($stable(cause_o) && $stable(epc_o))); // R5
  AST_IRQ_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (redirect_o && irq_i) |=> cause_o == 3'd0); // R3

endmodule

bind exc_commit_unit exc_commit_chk #(.PC_W(PC_W), .HANDLER_PC(HANDLER_PC)) i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .irq_i         (irq_i),
  .commit_valid_o(commit_valid_o),
  .commit_pc_o   (commit_pc_o),
  .redirect_o    (redirect_o),
  .redirect_pc_o (redirect_pc_o),
  .kill_wb_o     (kill_wb_o),
  .cause_o       (cause_o),
  .epc_o         (epc_o)
);

// File: tb/test_exc_commit_unit.sv
`timescale 1ns/1ps
module test_exc_commit_unit;

  localparam int          PC_W    = 32;
  localparam logic [31:0] HANDLER = 32'h0000_1000;

  typedef struct packed {
    logic        valid;
    logic [31:0] pc;
    logic        fflt;
    logic        ill;
    logic        ovf;
    logic        dflt;
    logic        irq;
    logic [23:0] tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        f_valid = 1'b0, f_fault = 1'b0, d_ill = 1'b0, e_ovf = 1'b0, m_dflt = 1'b0, irq = 1'b0;
  logic [31:0] f_pc = '0;
  logic        commit_valid, redirect, kill_f, kill_d, kill_e, kill_wb;
  logic [31:0] commit_pc, redirect_pc, epc;
  logic [2:0]  cause;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;
  bit mon_on = 1'b0;

  item_t q[$];
  item_t st0 = '0, st1 = '0, st2 = '0, st3 = '0;
  logic [31:0] next_pc = 32'h100;

  always #4 clk = ~clk;

  exc_commit_unit #(.PC_W(PC_W), .HANDLER_PC(HANDLER)) i_exc_commit_unit (
    .clk_i(clk), .rst_ni(rst_n),
    .f_valid_i(f_valid), .f_pc_i(f_pc), .f_pc_fault_i(f_fault),
    .d_illegal_i(d_ill), .e_overflow_i(e_ovf), .m_data_fault_i(m_dflt), .irq_i(irq),
    .commit_valid_o(commit_valid), .commit_pc_o(commit_pc),
    .redirect_o(redirect), .redirect_pc_o(redirect_pc),
    .kill_f_o(kill_f), .kill_d_o(kill_d), .kill_e_o(kill_e), .kill_wb_o(kill_wb),
    .cause_o(cause), .epc_o(epc)
  );

  task automatic chk(input bit ok, input logic [23:0] tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // driver: one slot per cycle; flags are presented when the item reaches each stage
  task automatic drive(input logic v, input logic ff, input logic il, input logic ov,
                       input logic df, input logic iq, input logic [23:0] tag);
    item_t it;
    it.valid = v; it.pc = next_pc; it.fflt = ff; it.ill = il; it.ovf = ov;
    it.dflt = df; it.irq = iq; it.tag = tag;
    next_pc = next_pc + 32'd4;
    @(posedge clk); #1;
    st3 = st2; st2 = st1; st1 = st0; st0 = it;
    q.push_back(it);
    f_valid = st0.valid; f_pc = st0.pc; f_fault = st0.fflt;
    d_ill = st1.ill; e_ovf = st2.ovf; m_dflt = st3.dflt; irq = st3.irq;
  endtask

  task automatic clean(input logic [23:0] tag);
    drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, tag);
  endtask

  // three shadow instructions carrying flags that must be discarded (R6)
  task automatic shadow();
    drive(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R6");
    drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, "R6");
    drive(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, "R6");
  endtask

  // monitor / scoreboard
  int          kill_cnt = 0;
  bit          chk_regs = 1'b0;
  logic [2:0]  exp_cause;
  logic [31:0] exp_epc;
  logic [23:0] reg_tag;

  always @(negedge clk) begin
    if (mon_on) begin
      if (chk_regs) begin
        chk(cause == exp_cause, "R5", "cause", {29'd0, cause}, {29'd0, exp_cause});
        chk(epc == exp_epc, "R5", "epc", epc, exp_epc);
        chk(cause == exp_cause, reg_tag, "cause code", {29'd0, cause}, {29'd0, exp_cause});
        chk_regs = 1'b0;
      end
      if (q.size() == 4) begin
        item_t it;
        bit live, tk;
        it = q.pop_front();
        live = it.valid && (kill_cnt == 0);
        if (kill_cnt > 0) kill_cnt--;
        tk = live && (it.irq || it.fflt || it.ill || it.ovf || it.dflt);
        chk(redirect == tk, it.tag, "redirect", {31'd0, redirect}, {31'd0, tk});
        chk(commit_valid == (live && !tk), it.tag, "commit",
            {31'd0, commit_valid}, {31'd0, live && !tk});
        if (live && !tk) chk(commit_pc == it.pc, "R9", "commit pc", commit_pc, it.pc);
        if (tk) begin
          chk(redirect_pc == HANDLER, "R7", "handler pc", redirect_pc, HANDLER);
          chk(kill_f && kill_d && kill_e && kill_wb, "R7", "kills",
              {28'd0, kill_f, kill_d, kill_e, kill_wb}, 32'hF);
          kill_cnt  = 3;
          exp_epc   = it.pc;
          reg_tag   = it.tag;
          exp_cause = it.irq ? 3'd0 : it.fflt ? 3'd1 : it.ill ? 3'd2 : it.ovf ? 3'd3 : 3'd4;
          chk_regs  = 1'b1;
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(cause == 3'd0, "R10", "reset cause", {29'd0, cause}, 32'd0);
    chk(epc == 32'd0, "R10", "reset epc", epc, 32'd0);
    chk(!redirect && !commit_valid, "R10", "reset outputs",
        {30'd0, redirect, commit_valid}, 32'd0);
    mon_on = 1'b1;

    for (int i = 0; i < 4; i++) clean("R9");
    // single faults, each deferred to the commit point (R1)
    drive(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R1"); shadow(); clean("R9");
    drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R1"); shadow(); clean("R9");
    drive(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R1"); shadow(); clean("R9");
    drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R1"); shadow(); clean("R9");
    // multiple faults on one instruction (R2)
    drive(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R2"); shadow();
    drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, "R2"); shadow();
    drive(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R2"); shadow();
    drive(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, "R2"); shadow();
    // interrupts (R3)
    drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R3"); shadow();
    drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, "R3"); shadow();
    // interrupt while a bubble sits in memory, then on a valid one (R4)
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R4");
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R4");
    drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R4"); shadow();
    // bubbles carrying every fault flag (R8)
    drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R8");
    drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R8");
    drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R8");
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R8");
    drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, "R8");
    for (int i = 0; i < 3; i++) clean("R9");
    for (int i = 0; i < 6; i++) drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R9");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule